// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block takes one reference clock at the processor rate and produces gated clock outputs for three groups of loads. The processor group and the memory group run at the reference rate. The peripheral-bus group runs at exactly half that rate and comes from a divider inside the block. Two active-low stop requests can arrive at any time, with no relation to the clock. Each is synchronized inside the block. The processor stop request is synchronized in the reference domain and the peripheral stop request in the half-rate domain. The synchronized request then closes or opens the outputs of its own group. Every enable changes only while its clock is low, so no output can show a shortened high pulse.

A mode strap sets whether the stop requests are honoured. While the strap is high, both requests are ignored and the two memory outputs that share pins with the request inputs run as ordinary clocks. While it is low, the requests are honoured and those two shared outputs stay low. One peripheral output is free-running and never obeys the peripheral stop request. An active-low power-down input overrides everything and forces every output low. After both domains have closed, the block also drops an oscillator enable. That enable rises again as soon as power-down is released, so the oscillator can restart before any synchronizer has a clock.

Top module: `clk_stop_ctl`

## Requirements
- R1: All control inputs (stop requests, mode, power-down) are sampled only through a synchronizer of SYNC_STAGES (default 2) flops. A processor stop pulse that starts and ends within one high phase of the reference, with no rising edge between, has no effect on any output.
- R2: With mode low and the processor stop request low (0 = stop), every cpu_clk_o bit is held low. Peripheral outputs and dedicated memory outputs keep running.
- R3: With mode low and the peripheral stop request low (0 = stop), every pci_clk_o bit is held low. Processor outputs keep running.
- R4: pci_free_o runs whenever power is up, whatever the state of the peripheral stop request.
- R5: With pwr_dn_n_i low (0 = power down), every output clock is held low: processor, all memory, all peripheral and the free-running one. The stop inputs and the mode input make no difference.
- R6: osc_en_o is high whenever pwr_dn_n_i is high, including during reset. It goes low only after power-down has closed the gates in both domains.
- R7: With mode high, both stop requests are ignored. The top N_SHARE bits of mem_clk_o run when mode is high and stay low when mode is low. The lower bits of mem_clk_o follow power only.
- R8: Every high pulse on a processor or memory output lasts half a reference period. Every high pulse on a peripheral output lasts one full reference period. No shortened pulse appears on any transition.
- R9: After the processor stop request changes between reference edges, the output state seen on the next SYNC_STAGES rising edges is the old state. The state at the following rising edge is the new state, which gives 2 to 3 reference cycles in total.
- R10: After the peripheral stop request changes between half-rate edges, the next SYNC_STAGES rising edges of the peripheral outputs show the old state. The following edge shows the new state.
- R11: Peripheral outputs have a period of two reference periods and a high time of one reference period.
- R12: During reset every output clock is low. After reset is released with no request and no power-down active, the processor outputs first pulse at the third rising reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock at processor rate |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = stop requests honoured; 1 = requests ignored and shared memory outputs run |
| cpu_halt_n_i | input | 1 | Processor stop request, active low, asynchronous |
| pci_halt_n_i | input | 1 | Peripheral stop request, active low, asynchronous |
| pwr_dn_n_i | input | 1 | Power-down, active low, asynchronous |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| mem_clk_o | output | N_MEM | Memory clocks; the top N_SHARE bits share pins with the request inputs |
| pci_clk_o | output | N_PCI | Gated half-rate peripheral clocks |
| pci_free_o | output | 1 | Free-running half-rate peripheral clock |
| osc_en_o | output | 1 | Enable for the oscillator and synthesizers |

## Verification
A request that changes between edges is visible at the third rising edge of its own domain: two synchronizer flops, then a falling-edge enable. The bench therefore drives every stimulus 1 ns after a rising edge. It samples each output 1 ns after the matching rising edge, on the reference for processor outputs and on the free-running output for the peripheral group, and it expects the old state on the first two edges and the new state on the third. For the steady-state sweep over mode, both requests and power, the bench waits twelve reference cycles before counting. It then counts rising edges over an eight-cycle window and expects exactly 8 or 0 per processor and memory output and exactly 4 or 0 per peripheral output. Separately, the bench times every high pulse on every output for the whole run, to catch shortened pulses.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // Control bundle synchronized into the reference (processor) domain
   typedef struct packed {
      logic share_on;   // mode strap high: shared memory pins act as clocks
      logic pwr_on;     // power-down not active
      logic run;        // processor group allowed to run
   } cpu_ctl_t;

   // Control bundle synchronized into the half-rate (peripheral) domain
   typedef struct packed {
      logic pwr_on;
      logic run;
   } pci_ctl_t;

   localparam int CPU_CTL_W = $bits(cpu_ctl_t);
   localparam int PCI_CTL_W = $bits(pci_ctl_t);
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   timeunit 1ns;
   timeprecision 1ps;

   if (STAGES < 2) begin : g_bad_depth
      $error("cs_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cs_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) chain_q <= '0;
      else          chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cs_halfdiv.sv
module cs_halfdiv (
   input  logic clk_i,
   input  logic rst_n_i,
   output logic div_o
);
   timeunit 1ns;
   timeprecision 1ps;

   logic half_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) half_q <= 1'b0;
      else          half_q <= ~half_q;
   end

   assign div_o = half_q;
endmodule

// File: rtl/cs_gate.sv
module cs_gate #(
   parameter int WIDTH = 1
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] en_i,
   output logic [WIDTH-1:0] gclk_o
);
   timeunit 1ns;
   timeprecision 1ps;

   if (WIDTH < 1) begin : g_bad_width
      $error("cs_gate: WIDTH must be at least 1");
   end

   // Enables move on the falling edge, while the clock is already low
   logic [WIDTH-1:0] en_q;

   always_ff @(negedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) en_q <= '0;
      else          en_q <= en_i;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_and
      assign gclk_o[i] = clk_i & en_q[i];
   end

   // R8: an enable may only move while its clock is low
   always @(en_q) begin
      if (rst_n_i) begin
         p_en_low_phase_r8: assert (clk_i == 1'b0)
            else $error("gate enable changed during high phase");
      end
   end
endmodule

// File: rtl/clk_stop_ctl.sv
module clk_stop_ctl
   import clk_stop_pkg::*;
#(
   parameter int N_CPU       = 4,
   parameter int N_MEM       = 8,
   parameter int N_SHARE     = 2,
   parameter int N_PCI       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             mode_i,
   input  logic             cpu_halt_n_i,
   input  logic             pci_halt_n_i,
   input  logic             pwr_dn_n_i,
   output logic [N_CPU-1:0] cpu_clk_o,
   output logic [N_MEM-1:0] mem_clk_o,
   output logic [N_PCI-1:0] pci_clk_o,
   output logic             pci_free_o,
   output logic             osc_en_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int N_DED  = N_MEM - N_SHARE;   // memory outputs driven by power only
   localparam int N_CDOM = N_CPU + N_MEM;     // outputs gated in the reference domain
   localparam int N_PDOM = N_PCI + 1;         // outputs gated in the half-rate domain

   if (N_CPU < 1 || N_PCI < 1) begin : g_bad_count
      $error("clk_stop_ctl: need at least one processor and one peripheral output");
   end
   if (N_SHARE < 0 || N_SHARE > N_MEM) begin : g_bad_share
      $error("clk_stop_ctl: N_SHARE must lie within 0..N_MEM");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clk_stop_ctl: SYNC_STAGES must be at least 2");
   end

   // ---------------- reference domain control ----------------
   cpu_ctl_t             cpu_req, cpu_s;
   logic [CPU_CTL_W-1:0] cpu_s_vec;

   always_comb begin
      cpu_req.run      = cpu_halt_n_i | mode_i;
      cpu_req.pwr_on   = pwr_dn_n_i;
      cpu_req.share_on = mode_i;
   end

   cs_sync #(.WIDTH(CPU_CTL_W), .STAGES(SYNC_STAGES)) u_cpu_sync (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .d_i     (cpu_req),
      .q_o     (cpu_s_vec)
   );
   assign cpu_s = cpu_ctl_t'(cpu_s_vec);

   logic [N_CDOM-1:0] cdom_en, cdom_clk;

   for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_en
      assign cdom_en[i] = cpu_s.run & cpu_s.pwr_on;
   end
   for (genvar j = 0; j < N_MEM; j++) begin : g_mem_en
      if (j < N_DED) begin : g_ded
         assign cdom_en[N_CPU+j] = cpu_s.pwr_on;
      end else begin : g_shr
         assign cdom_en[N_CPU+j] = cpu_s.pwr_on & cpu_s.share_on;
      end
   end

   cs_gate #(.WIDTH(N_CDOM)) u_cpu_gate (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .en_i    (cdom_en),
      .gclk_o  (cdom_clk)
   );

   assign cpu_clk_o = cdom_clk[N_CPU-1:0];
   assign mem_clk_o = cdom_clk[N_CDOM-1:N_CPU];

   // ---------------- half-rate domain ----------------
   logic pci_ref;

   cs_halfdiv u_div (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .div_o   (pci_ref)
   );

   pci_ctl_t             pci_req, pci_s;
   logic [PCI_CTL_W-1:0] pci_s_vec;

   always_comb begin
      pci_req.run    = pci_halt_n_i | mode_i;
      pci_req.pwr_on = pwr_dn_n_i;
   end

   cs_sync #(.WIDTH(PCI_CTL_W), .STAGES(SYNC_STAGES)) u_pci_sync (
      .clk_i   (pci_ref),
      .rst_n_i (rst_n_i),
      .d_i     (pci_req),
      .q_o     (pci_s_vec)
   );
   assign pci_s = pci_ctl_t'(pci_s_vec);

   logic [N_PDOM-1:0] pdom_en, pdom_clk;

   for (genvar k = 0; k < N_PCI; k++) begin : g_pci_en
      assign pdom_en[k] = pci_s.run & pci_s.pwr_on;
   end
   assign pdom_en[N_PCI] = pci_s.pwr_on;

   cs_gate #(.WIDTH(N_PDOM)) u_pci_gate (
      .clk_i   (pci_ref),
      .rst_n_i (rst_n_i),
      .en_i    (pdom_en),
      .gclk_o  (pdom_clk)
   );

   assign pci_clk_o  = pdom_clk[N_PCI-1:0];
   assign pci_free_o = pdom_clk[N_PCI];

   // ---------------- oscillator enable ----------------
   // Power flags held on the falling edge: they drop together with the gates
   logic cpu_pwr_hold, pci_pwr_hold;

   always_ff @(negedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) cpu_pwr_hold <= 1'b0;
      else          cpu_pwr_hold <= cpu_s.pwr_on;
   end

   always_ff @(negedge pci_ref or negedge rst_n_i) begin
      if (!rst_n_i) pci_pwr_hold <= 1'b0;
      else          pci_pwr_hold <= pci_s.pwr_on;
   end

   // Release of power-down restarts the oscillator without waiting for a clock
   assign osc_en_o = pwr_dn_n_i | cpu_pwr_hold | pci_pwr_hold;

   // ---------------- assertions ----------------
   p_cpu_stop_r2: assert property (@(negedge clk_i) disable iff (!rst_n_i)
      !(cpu_s.run && cpu_s.pwr_on) |=> (cpu_clk_o == '0));

   p_pwr_off_r5: assert property (@(negedge clk_i) disable iff (!rst_n_i)
      !cpu_s.pwr_on |=> (cpu_clk_o == '0 && mem_clk_o == '0));

   if (N_SHARE > 0) begin : g_share_chk
      p_share_off_r7: assert property (@(negedge clk_i) disable iff (!rst_n_i)
         !cpu_s.share_on |=> (mem_clk_o[N_MEM-1:N_DED] == '0));
   end

   p_pci_stop_r3: assert property (@(negedge pci_ref) disable iff (!rst_n_i)
      !(pci_s.run && pci_s.pwr_on) |=> (pci_clk_o == '0));

   p_free_run_r4: assert property (@(negedge pci_ref) disable iff (!rst_n_i)
      pci_s.pwr_on |=> pci_free_o);

   p_osc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      pwr_dn_n_i |-> osc_en_o);
endmodule

// File: tb/test_clk_stop_ctl.sv
module test_clk_stop_ctl;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NC = 4, NM = 8, NS = 2, NP = 6;
   localparam int NALL = NC + NM + NP + 1;
   localparam int MEM0 = NC, SHR0 = NC + NM - NS, PCI0 = NC + NM, FREE = NALL - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic mode = 1'b0, cpu_halt_n = 1'b1, pci_halt_n = 1'b1, pwr_n = 1'b1;
   logic [NC-1:0] cpu_o;
   logic [NM-1:0] mem_o;
   logic [NP-1:0] pci_o;
   logic free_o, osc_o;

   always #2.5 clk = ~clk;

   clk_stop_ctl #(.N_CPU(NC), .N_MEM(NM), .N_SHARE(NS), .N_PCI(NP), .SYNC_STAGES(2))
   i_clk_stop_ctl (
      .clk_i(clk), .rst_n_i(rst_n), .mode_i(mode), .cpu_halt_n_i(cpu_halt_n),
      .pci_halt_n_i(pci_halt_n), .pwr_dn_n_i(pwr_n), .cpu_clk_o(cpu_o),
      .mem_clk_o(mem_o), .pci_clk_o(pci_o), .pci_free_o(free_o), .osc_en_o(osc_o)
   );

   int n_tests = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Pulse monitor: rising-edge counts and high-time check on every output (R8)
   logic [NALL-1:0] all_o, prev_o = '0;
   int     rise_cnt [NALL];
   realtime t_rise  [NALL];
   assign all_o = {free_o, pci_o, mem_o, cpu_o};

   initial for (int b = 0; b < NALL; b++) begin rise_cnt[b] = 0; t_rise[b] = -1.0; end

   always @(all_o) begin
      for (int b = 0; b < NALL; b++) begin
         if (all_o[b] && !prev_o[b]) begin
            rise_cnt[b]++;
            t_rise[b] = $realtime;
         end else if (!all_o[b] && prev_o[b] && t_rise[b] >= 0.0) begin
            realtime w, wexp;
            w    = $realtime - t_rise[b];
            wexp = (b >= PCI0) ? 5.0 : 2.5;
            chk((w > wexp - 0.01) && (w < wexp + 0.01), "R8", $sformatf("high ps bit %0d", b),
                longint'(w * 1000.0), longint'(wexp * 1000.0));
         end
      end
      prev_o = all_o;
   end

   task automatic after_ref(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic after_pci(input int n);
      repeat (n) @(posedge free_o);
      #1;
   endtask

   initial begin
      #200us;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int c0;
      realtime ta, tb;

      // R12: reset state
      after_ref(3);
      chk(all_o == '0, "R12", "outputs in reset", longint'(all_o), 0);
      chk(osc_o == 1'b1, "R6", "osc in reset", osc_o, 1);

      // R12: first pulse on the third edge after release
      rst_n = 1'b1;
      for (int e = 1; e <= 3; e++) begin
         after_ref(1);
         chk(cpu_o == ((e < 3) ? '0 : '1), "R12", $sformatf("cpu after release edge %0d", e),
             cpu_o, (e < 3) ? 0 : 15);
      end
      after_ref(10);

      // R11: peripheral period
      @(posedge free_o); ta = $realtime;
      @(posedge free_o); tb = $realtime;
      chk((tb - ta) > 9.99 && (tb - ta) < 10.01, "R11", "pci period ps",
          longint'((tb - ta) * 1000.0), 10000);

      // R9 / R2: processor stop latency, peripheral unaffected
      after_ref(1);
      cpu_halt_n = 1'b0;
      for (int e = 1; e <= 3; e++) begin
         after_ref(1);
         chk(cpu_o == ((e < 3) ? '1 : '0), "R9", $sformatf("stop edge %0d", e),
             cpu_o, (e < 3) ? 15 : 0);
      end
      after_pci(1);
      chk(pci_o == '1, "R2", "pci during cpu stop", pci_o, 63);
      after_ref(1);
      cpu_halt_n = 1'b1;
      for (int e = 1; e <= 3; e++) begin
         after_ref(1);
         chk(cpu_o == ((e < 3) ? '0 : '1), "R9", $sformatf("start edge %0d", e),
             cpu_o, (e < 3) ? 0 : 15);
      end

      // R10 / R3 / R4: peripheral stop latency
      after_pci(1);
      pci_halt_n = 1'b0;
      for (int e = 1; e <= 3; e++) begin
         after_pci(1);
         chk(pci_o == ((e < 3) ? '1 : '0), "R10", $sformatf("stop edge %0d", e),
             pci_o, (e < 3) ? 63 : 0);
         chk(free_o == 1'b1, "R4", "free during pci stop", free_o, 1);
         chk(cpu_o == '1, "R3", "cpu during pci stop", cpu_o, 15);
      end
      after_pci(1);
      pci_halt_n = 1'b1;
      for (int e = 1; e <= 3; e++) begin
         after_pci(1);
         chk(pci_o == ((e < 3) ? '0 : '1), "R10", $sformatf("start edge %0d", e),
             pci_o, (e < 3) ? 0 : 63);
      end

      // R1: short stop pulse inside one high phase is not seen
      after_ref(1);
      c0 = rise_cnt[0];
      cpu_halt_n = 1'b0;
      #1 cpu_halt_n = 1'b1;
      after_ref(8);
      chk(rise_cnt[0] - c0 == 8, "R1", "cpu pulses after short request", rise_cnt[0] - c0, 8);

      // Sweep over mode, both requests and power
      for (int m = 0; m < 2; m++)
         for (int ch = 0; ch < 2; ch++)
            for (int ph = 0; ph < 2; ph++)
               for (int pw = 0; pw < 2; pw++) begin
                  int snap [NALL];
                  after_ref(1);
                  mode = m[0]; cpu_halt_n = ch[0]; pci_halt_n = ph[0]; pwr_n = pw[0];
                  after_ref(12);
                  chk(osc_o == pw[0], "R6", $sformatf("osc m%0d c%0d p%0d w%0d", m, ch, ph, pw),
                      osc_o, pw);
                  for (int b = 0; b < NALL; b++) snap[b] = rise_cnt[b];
                  after_ref(8);
                  for (int b = 0; b < NALL; b++) begin
                     bit    on;
                     int    per;
                     string tag;
                     if (b < MEM0)      begin on = pw[0] & (m[0] | ch[0]); tag = "R2"; end
                     else if (b < SHR0) begin on = pw[0];                  tag = "R5"; end
                     else if (b < PCI0) begin on = pw[0] & m[0];           tag = "R7"; end
                     else if (b < FREE) begin on = pw[0] & (m[0] | ph[0]); tag = "R3"; end
                     else               begin on = pw[0];                  tag = "R4"; end
                     if (pw == 0) tag = "R5";
                     per = (b >= PCI0) ? 4 : 8;
                     chk(rise_cnt[b] - snap[b] == (on ? per : 0), tag,
                         $sformatf("pulses bit %0d m%0d c%0d p%0d w%0d", b, m, ch, ph, pw),
                         rise_cnt[b] - snap[b], on ? per : 0);
                  end
               end

      // R6: oscillator enable returns at once on power-up
      after_ref(1);
      mode = 1'b0; cpu_halt_n = 1'b1; pci_halt_n = 1'b1; pwr_n = 1'b0;
      #0.5;
      chk(osc_o == 1'b1, "R6", "osc just after power-down request", osc_o, 1);
      after_ref(12);
      chk(osc_o == 1'b0, "R6", "osc after power-down settles", osc_o, 0);
      pwr_n = 1'b1;
      #0.5;
      chk(osc_o == 1'b1, "R6", "osc on power-up release", osc_o, 1);
      after_ref(12);
      chk(cpu_o == '1, "R5", "cpu after power return", cpu_o, 15);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule